// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is a compact 16-bit accumulator processor core that steps each instruction through fetch, decode, an optional indirect-address step and execution. It holds a 12-bit program counter and address register, a 16-bit instruction register, data register and accumulator, a single carry/link bit and a run flag. All register transfers pass over one internal word-wide bus whose source is picked by a 3-bit select code. The core talks to a 4096-word by 16-bit memory whose reads are combinational on the address and whose writes land on the rising clock edge.

A 4-bit step counter yields one-hot timing strobes, and a 3-to-8 decoder turns the opcode field into one-hot operation lines. Every instruction clears the step counter when it finishes, so the next fetch always begins at step 0. Memory-reference and register-reference instructions run here. Input/output instructions are handed to a neighbouring block through a one-cycle request carrying the instruction's low twelve bits.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high reset leaves the program counter, accumulator and carry bit at 0 with the core running (`halted` low). The first clock edge after reset releases puts address 0 on `mem_addr`.
- R2: An instruction word is read from the address held in the program counter, and the program counter then advances by one. Bits 11..0 are the address, bits 14..12 the opcode and bit 15 the indirect flag.
- R3: For opcodes 0..6 with bit 15 set, the effective address is the word read from the address field. Direct and indirect forms take the same number of cycles.
- R4: Opcode 0 ANDs the memory word into the accumulator. Opcode 1 adds it and places the carry-out in the carry bit. Opcode 2 loads it.
- R5: Opcode 3 stores the accumulator at the effective address. Opcodes 3, 5 and 6 each issue exactly one memory write per instruction, and no other instruction issues one.
- R6: Opcode 4 jumps to the effective address. Opcode 5 stores the return address at the effective address and continues at the effective address plus one.
- R7: Opcode 6 increments the memory word in place and skips the next instruction when the result is zero.
- R8: Opcode 7 with bit 15 clear selects register operations by low-field bit. 0x800 clears the accumulator, 0x400 clears carry, 0x200 complements the accumulator and 0x100 complements carry. 0x080 rotates the accumulator and carry right, with carry entering bit 15. 0x040 rotates left, with carry entering bit 0. 0x020 increments the accumulator and leaves carry alone.
- R9: The register skips advance the program counter once more when their condition holds. 0x010 skips on accumulator bit 15 clear, 0x008 on bit 15 set, 0x004 on an accumulator of zero and 0x002 on a carry of zero.
- R10: 0x001 halts the core: `halted` rises, and afterwards the program counter holds and no memory write occurs until reset.
- R11: Register and I/O instructions take 4 cycles. Store and jump take 5. AND, add, load and subroutine call take 6. Increment-and-skip takes 7.
- R12: Opcode 7 with bit 15 set raises `io_req` for exactly one cycle, with `io_code` equal to the low 12 bits, and leaves the accumulator and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_rdata | input | 16 | Memory read data, combinational on `mem_addr` |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable for the coming edge |
| io_req | output | 1 | One-cycle request for an I/O instruction |
| io_code | output | 12 | Low 12 bits of the I/O instruction |
| acc_out | output | 16 | Accumulator value |
| carry_out | output | 1 | Carry/link bit value |
| pc_out | output | 12 | Program counter value |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Each case runs a short program that sets the carry bit, loads the accumulator and then executes one instruction under test followed by a halt. The final accumulator, carry, program counter, a chosen memory word, the write count and the cycle count together separate one opcode's data path from another's. Operand pairs are chosen so that a missing carry, a carry left stale, a rotate in the wrong direction or a skip that always or never fires each yields a value that differs from the expected one. Indirect forms point through a fixed pointer word, so a core that skips the indirect step reads the wrong operand. A jump lands on a halt placed in the operand word, and the skip pairs differ only in whether their condition holds.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 12;
  localparam int OPC_W   = 3;
  localparam int OPC_LSB = ADDR_W;
  localparam int IND_BIT = WORD_W - 1;
  localparam int N_OPS   = 1 << OPC_W;
  localparam int N_SRC   = 7;
  localparam int SEL_W   = $clog2(N_SRC + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [SEL_W-1:0] {
    BUS_NONE = 3'd0,
    BUS_AR   = 3'd1,
    BUS_PC   = 3'd2,
    BUS_DR   = 3'd3,
    BUS_AC   = 3'd4,
    BUS_IR   = 3'd5,
    BUS_TR   = 3'd6,
    BUS_MEM  = 3'd7
  } bus_sel_e;

  localparam int OP_AND = 0;
  localparam int OP_ADD = 1;
  localparam int OP_LDA = 2;
  localparam int OP_STA = 3;
  localparam int OP_BUN = 4;
  localparam int OP_BSA = 5;
  localparam int OP_ISZ = 6;
  localparam int OP_EXT = 7;

  localparam int RB_CLRA = 11;
  localparam int RB_CLRE = 10;
  localparam int RB_CPLA = 9;
  localparam int RB_CPLE = 8;
  localparam int RB_ROTR = 7;
  localparam int RB_ROTL = 6;
  localparam int RB_INCA = 5;
  localparam int RB_SPOS = 4;
  localparam int RB_SNEG = 3;
  localparam int RB_SZRA = 2;
  localparam int RB_SZRE = 1;
  localparam int RB_HALT = 0;

  // sum with carry-out in the top bit
  function automatic logic [WORD_W:0] add_carry(input word_t a, input word_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // returns {new_link, new_acc}
  function automatic logic [WORD_W:0] rot_right(input word_t a, input logic lnk);
    return {a[0], lnk, a[WORD_W-1:1]};
  endfunction

  function automatic logic [WORD_W:0] rot_left(input word_t a, input logic lnk);
    return {a[WORD_W-1], a[WORD_W-2:0], lnk};
  endfunction
endpackage

// File: rtl/acc_timing_gen.sv
module acc_timing_gen #(
  parameter int SC_W = 4,
  localparam int T_N = 1 << SC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           sc_clr,
  output logic [T_N-1:0] t_vec
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst || sc_clr) sc_q <= '0;
    else if (run)      sc_q <= sc_q + 1'b1;
  end

  for (genvar k = 0; k < T_N; k++) begin : g_strobe
    assign t_vec[k] = run && (sc_q == SC_W'(k));
  end
endmodule

// File: rtl/acc_op_decoder.sv
module acc_op_decoder #(
  parameter int OPC_W = 3,
  localparam int N = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc,
  output logic [N-1:0]     d_vec
);
  for (genvar k = 0; k < N; k++) begin : g_line
    assign d_vec[k] = (opc == OPC_W'(k));
  end
endmodule

// File: rtl/acc_bus_encoder.sv
module acc_bus_encoder #(
  parameter int N_SRC = 7,
  localparam int SEL_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:1]    src_req,
  output logic [SEL_W-1:0]  sel
);
  always_comb begin
    sel = '0;
    for (int k = 1; k <= N_SRC; k++) begin
      if (src_req[k]) sel = SEL_W'(k);
    end
  end
endmodule

// File: rtl/acc_reg_ops.sv
module acc_reg_ops
  import acc_cpu_pkg::*;
(
  input  word_t       ac,
  input  logic        lnk,
  input  addr_t       ctl,
  output word_t       ac_nx,
  output logic        lnk_nx,
  output logic        skip,
  output logic        halt
);
  logic [WORD_W:0] rr, rl;

  always_comb begin
    ac_nx  = ac;
    lnk_nx = lnk;
    if (ctl[RB_CLRA]) ac_nx  = '0;
    if (ctl[RB_CLRE]) lnk_nx = 1'b0;
    if (ctl[RB_CPLA]) ac_nx  = ~ac_nx;
    if (ctl[RB_CPLE]) lnk_nx = ~lnk_nx;
    rr = rot_right(ac_nx, lnk_nx);
    if (ctl[RB_ROTR]) {lnk_nx, ac_nx} = rr;
    rl = rot_left(ac_nx, lnk_nx);
    if (ctl[RB_ROTL]) {lnk_nx, ac_nx} = rl;
    if (ctl[RB_INCA]) ac_nx = ac_nx + 1'b1;
  end

  assign skip = (ctl[RB_SPOS] && !ac[WORD_W-1]) ||
                (ctl[RB_SNEG] &&  ac[WORD_W-1]) ||
                (ctl[RB_SZRA] && (ac == '0))    ||
                (ctl[RB_SZRE] && !lnk);
  assign halt = ctl[RB_HALT];
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int SC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              io_req,
  output logic [ADDR_W-1:0] io_code,
  output logic [WORD_W-1:0] acc_out,
  output logic              carry_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              halted
);
  localparam int T_N = 1 << SC_W;

  addr_t ar_q, pc_q;
  word_t ir_q, dr_q, ac_q;
  logic  e_q, i_q, run_q;

  logic [T_N-1:0]   t_vec;
  logic [N_OPS-1:0] d_vec;
  logic [N_SRC:1]   src_req;
  logic [SEL_W-1:0] bus_sel_raw;
  bus_sel_e         bus_sel;
  word_t            bus;

  // named events shared with the checker
  logic mem_ref, ind_step, r_exec, p_exec, dr_load, sc_clr, skip_now;
  logic [WORD_W:0] sum;
  word_t rop_ac;
  logic  rop_e, rop_skip, rop_halt;

  acc_timing_gen #(.SC_W(SC_W)) u_timing (
    .clk(clk), .rst(rst), .run(run_q), .sc_clr(sc_clr), .t_vec(t_vec)
  );

  acc_op_decoder #(.OPC_W(OPC_W)) u_dec (
    .opc(ir_q[OPC_LSB +: OPC_W]), .d_vec(d_vec)
  );

  acc_bus_encoder #(.N_SRC(N_SRC)) u_enc (
    .src_req(src_req), .sel(bus_sel_raw)
  );

  acc_reg_ops u_rops (
    .ac(ac_q), .lnk(e_q), .ctl(ir_q[ADDR_W-1:0]),
    .ac_nx(rop_ac), .lnk_nx(rop_e), .skip(rop_skip), .halt(rop_halt)
  );

  assign mem_ref  = !d_vec[OP_EXT];
  assign ind_step = mem_ref && i_q && t_vec[3];
  assign r_exec   = d_vec[OP_EXT] && !i_q && t_vec[3];
  assign p_exec   = d_vec[OP_EXT] &&  i_q && t_vec[3];
  assign dr_load  = (d_vec[OP_AND] || d_vec[OP_ADD] || d_vec[OP_LDA] ||
                     d_vec[OP_ISZ]) && t_vec[4];

  assign src_req[BUS_AR]  = (d_vec[OP_BUN] && t_vec[4]) || (d_vec[OP_BSA] && t_vec[5]);
  assign src_req[BUS_PC]  = t_vec[0] || (d_vec[OP_BSA] && t_vec[4]);
  assign src_req[BUS_DR]  = d_vec[OP_ISZ] && t_vec[6];
  assign src_req[BUS_AC]  = d_vec[OP_STA] && t_vec[4];
  assign src_req[BUS_IR]  = t_vec[2];
  assign src_req[BUS_TR]  = 1'b0;
  assign src_req[BUS_MEM] = t_vec[1] || ind_step || dr_load;

  assign bus_sel = bus_sel_e'(bus_sel_raw);

  always_comb begin
    case (bus_sel)
      BUS_AR:  bus = WORD_W'(ar_q);
      BUS_PC:  bus = WORD_W'(pc_q);
      BUS_DR:  bus = dr_q;
      BUS_AC:  bus = ac_q;
      BUS_IR:  bus = ir_q;
      BUS_MEM: bus = mem_rdata;
      default: bus = '0;
    endcase
  end

  assign sum = add_carry(ac_q, dr_q);

  assign sc_clr = r_exec || p_exec ||
                  ((d_vec[OP_AND] || d_vec[OP_ADD] || d_vec[OP_LDA] ||
                    d_vec[OP_BSA]) && t_vec[5]) ||
                  ((d_vec[OP_STA] || d_vec[OP_BUN]) && t_vec[4]) ||
                  (d_vec[OP_ISZ] && t_vec[6]);

  assign skip_now = (r_exec && rop_skip) ||
                    (d_vec[OP_ISZ] && t_vec[6] && (dr_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q  <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      ac_q  <= '0;
      e_q   <= 1'b0;
      i_q   <= 1'b0;
      run_q <= 1'b1;
    end else begin
      if (t_vec[0] || t_vec[2] || ind_step) ar_q <= bus[ADDR_W-1:0];
      else if (d_vec[OP_BSA] && t_vec[4])   ar_q <= ar_q + 1'b1;

      if (t_vec[1] || skip_now) pc_q <= pc_q + 1'b1;
      else if ((d_vec[OP_BUN] && t_vec[4]) || (d_vec[OP_BSA] && t_vec[5]))
        pc_q <= bus[ADDR_W-1:0];

      if (t_vec[1]) ir_q <= bus;
      if (t_vec[2]) i_q  <= ir_q[IND_BIT];

      if (dr_load)                          dr_q <= bus;
      else if (d_vec[OP_ISZ] && t_vec[5])   dr_q <= dr_q + 1'b1;

      if (d_vec[OP_AND] && t_vec[5]) ac_q <= ac_q & dr_q;
      if (d_vec[OP_ADD] && t_vec[5]) {e_q, ac_q} <= sum;
      if (d_vec[OP_LDA] && t_vec[5]) ac_q <= dr_q;
      if (r_exec) begin
        ac_q <= rop_ac;
        e_q  <= rop_e;
        if (rop_halt) run_q <= 1'b0;
      end
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = bus;
  assign mem_we    = (d_vec[OP_STA] && t_vec[4]) || (d_vec[OP_BSA] && t_vec[4]) ||
                     (d_vec[OP_ISZ] && t_vec[6]);
  assign io_req    = p_exec;
  assign io_code   = ir_q[ADDR_W-1:0];
  assign acc_out   = ac_q;
  assign carry_out = e_q;
  assign pc_out    = pc_q;
  assign halted    = !run_q;
endmodule

// File: rtl/acc_cpu_core_checker.sv
module acc_cpu_core_checker #(
  parameter int T_N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [T_N-1:0] t_vec,
  input logic [7:1]     src_req,
  input logic [2:0]     bus_sel,
  input logic           mem_we,
  input logic           run,
  input logic           sc_clr,
  input logic           io_req,
  input logic [11:0]    pc
);
  assert_bus_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_req));

  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
    t_vec[1] |=> (pc == $past(pc) + 12'd1));

  assert_write_source_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bus_sel != 3'd0 && bus_sel != 3'd7));

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!run && $stable(pc) && !mem_we));

  assert_step_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(t_vec));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (sc_clr && run) |=> (t_vec[0] || !run));

  assert_io_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    io_req |=> !io_req);
endmodule

bind acc_cpu_core acc_cpu_core_checker u_chk (
  .clk(clk), .rst(rst), .t_vec(t_vec), .src_req(src_req),
  .bus_sel(bus_sel_raw), .mem_we(mem_we), .run(run_q), .sc_clr(sc_clr),
  .io_req(io_req), .pc(pc_q)
);

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;
  localparam int CLK_P = 10;
  localparam int NV    = 33;

  typedef struct packed {
    logic [15:0] ac0;
    logic        e0;
    logic [15:0] ins;
    logic [15:0] opd;
    logic [15:0] x_ac;
    logic        x_e;
    logic [11:0] x_pc;
    logic [11:0] c_adr;
    logic [15:0] x_mem;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'hF0F0,1'b0,16'h0102,16'h3CC3,16'h30C0,1'b0,12'h004,12'h102,16'h3CC3},
    '{16'h1234,1'b0,16'h1102,16'h0101,16'h1335,1'b0,12'h004,12'h102,16'h0101},
    '{16'hFFFF,1'b0,16'h1102,16'h0002,16'h0001,1'b1,12'h004,12'h102,16'h0002},
    '{16'h8000,1'b1,16'h9103,16'h8001,16'h0001,1'b1,12'h004,12'h102,16'h8001},
    '{16'h0001,1'b1,16'h1102,16'h0001,16'h0002,1'b0,12'h004,12'h102,16'h0001},
    '{16'h5555,1'b0,16'hA103,16'hBEEF,16'hBEEF,1'b0,12'h004,12'h102,16'hBEEF},
    '{16'hFFFF,1'b0,16'h8103,16'h1234,16'h1234,1'b0,12'h004,12'h102,16'h1234},
    '{16'h4242,1'b0,16'h3102,16'h0000,16'h4242,1'b0,12'h004,12'h102,16'h4242},
    '{16'h0A0A,1'b0,16'hB103,16'h0000,16'h0A0A,1'b0,12'h004,12'h102,16'h0A0A},
    '{16'h0007,1'b0,16'h4004,16'h0000,16'h0007,1'b0,12'h005,12'h102,16'h0000},
    '{16'h0007,1'b0,16'hC103,16'h7001,16'h0007,1'b0,12'h103,12'h102,16'h7001},
    '{16'h0009,1'b0,16'h5104,16'h0000,16'h0009,1'b0,12'h106,12'h104,16'h0003},
    '{16'h0001,1'b0,16'h6102,16'h0041,16'h0001,1'b0,12'h004,12'h102,16'h0042},
    '{16'h0001,1'b0,16'h6102,16'hFFFF,16'h0001,1'b0,12'h005,12'h102,16'h0000},
    '{16'h0001,1'b0,16'hE103,16'hFFFF,16'h0001,1'b0,12'h005,12'h102,16'h0000},
    '{16'h1234,1'b1,16'h7800,16'h0000,16'h0000,1'b1,12'h004,12'h102,16'h0000},
    '{16'h1234,1'b1,16'h7400,16'h0000,16'h1234,1'b0,12'h004,12'h102,16'h0000},
    '{16'h00FF,1'b0,16'h7200,16'h0000,16'hFF00,1'b0,12'h004,12'h102,16'h0000},
    '{16'h0001,1'b0,16'h7100,16'h0000,16'h0001,1'b1,12'h004,12'h102,16'h0000},
    '{16'h0003,1'b1,16'h7080,16'h0000,16'h8001,1'b1,12'h004,12'h102,16'h0000},
    '{16'h0002,1'b0,16'h7080,16'h0000,16'h0001,1'b0,12'h004,12'h102,16'h0000},
    '{16'h8001,1'b0,16'h7040,16'h0000,16'h0002,1'b1,12'h004,12'h102,16'h0000},
    '{16'hFFFF,1'b1,16'h7020,16'h0000,16'h0000,1'b1,12'h004,12'h102,16'h0000},
    '{16'h7FFF,1'b0,16'h7010,16'h0000,16'h7FFF,1'b0,12'h005,12'h102,16'h0000},
    '{16'h8000,1'b0,16'h7010,16'h0000,16'h8000,1'b0,12'h004,12'h102,16'h0000},
    '{16'h8000,1'b0,16'h7008,16'h0000,16'h8000,1'b0,12'h005,12'h102,16'h0000},
    '{16'h0001,1'b0,16'h7008,16'h0000,16'h0001,1'b0,12'h004,12'h102,16'h0000},
    '{16'h0000,1'b0,16'h7004,16'h0000,16'h0000,1'b0,12'h005,12'h102,16'h0000},
    '{16'h0001,1'b0,16'h7004,16'h0000,16'h0001,1'b0,12'h004,12'h102,16'h0000},
    '{16'h0001,1'b0,16'h7002,16'h0000,16'h0001,1'b0,12'h005,12'h102,16'h0000},
    '{16'h0001,1'b1,16'h7002,16'h0000,16'h0001,1'b1,12'h004,12'h102,16'h0000},
    '{16'h1111,1'b0,16'hF800,16'h0000,16'h1111,1'b0,12'h004,12'h102,16'h0000},
    '{16'h0000,1'b1,16'hF040,16'h0000,16'h0000,1'b1,12'h004,12'h102,16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata, mem_wdata;
  logic        mem_we, io_req, carry_out, halted;
  logic [11:0] io_code, pc_out;
  logic [15:0] acc_out;

  logic [15:0] mem [4096];
  int nchk = 0;
  int nfail = 0;
  int we_cnt = 0;
  int io_cnt = 0;
  logic [11:0] io_last = '0;

  always #(CLK_P/2) clk = ~clk;

  acc_cpu_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .io_req(io_req), .io_code(io_code),
    .acc_out(acc_out), .carry_out(carry_out), .pc_out(pc_out), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (io_req) begin
      io_cnt  <= io_cnt + 1;
      io_last <= io_code;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] ins);
    logic [2:0] op = ins[14:12];
    if (op != 3'd7 && ins[15]) return "R3";
    case (op)
      3'd0, 3'd1, 3'd2: return "R4";
      3'd3:             return "R5";
      3'd4, 3'd5:       return "R6";
      3'd6:             return "R7";
      default:          return ins[15] ? "R12" : ((ins[11:5] != 0) ? "R8" : "R9");
    endcase
  endfunction

  function automatic int len_of(input logic [15:0] ins);
    case (ins[14:12])
      3'd7:             return 4;
      3'd3, 3'd4:       return 5;
      3'd6:             return 7;
      default:          return 6;
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int cyc = 0;
    int we_exp;
    logic [11:0] pc_hold;
    string t;
    t = tag_of(v.ins);
    rst = 1'b1;
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
    mem[12'h000] = v.e0 ? 16'h7100 : 16'h7000;
    mem[12'h001] = 16'h2100;
    mem[12'h002] = v.ins;
    mem[12'h003] = 16'h7001;
    mem[12'h004] = 16'h7001;
    mem[12'h100] = v.ac0;
    mem[12'h102] = v.opd;
    mem[12'h103] = 16'h0102;
    mem[12'h105] = 16'h7001;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1", "reset pc", 32'(pc_out), 32'h0);
    check("R1", "reset acc", 32'(acc_out), 32'h0);
    check("R1", "reset carry", 32'(carry_out), 32'h0);
    check("R1", "reset halted", 32'(halted), 32'h0);
    we_cnt = 0;
    io_cnt = 0;
    rst = 1'b0;
    while (!halted && cyc < 200) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) check("R1", "first fetch address", 32'(mem_addr), 32'h0);
      if (cyc == 2) check("R2", "pc after fetch", 32'(pc_out), 32'h1);
    end
    check("R11", "cycles to halt", 32'(cyc), 32'(14 + len_of(v.ins)));
    check(t, "acc", 32'(acc_out), 32'(v.x_ac));
    check(t, "carry", 32'(carry_out), 32'(v.x_e));
    check(t, "pc", 32'(pc_out), 32'(v.x_pc));
    check(t, "memory word", 32'(mem[v.c_adr]), 32'(v.x_mem));
    we_exp = (v.ins[14:12] == 3'd3 || v.ins[14:12] == 3'd5 || v.ins[14:12] == 3'd6) ? 1 : 0;
    check("R5", "write count", 32'(we_cnt), 32'(we_exp));
    if (v.ins[15:12] == 4'hF) begin
      check("R12", "io pulses", 32'(io_cnt), 32'h1);
      check("R12", "io code", 32'(io_last), 32'(v.ins[11:0]));
    end else begin
      check("R12", "io pulses", 32'(io_cnt), 32'h0);
    end
    pc_hold = pc_out;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10", "halted held", 32'(halted), 32'h1);
    check("R10", "pc frozen", 32'(pc_out), 32'(pc_hold));
    check("R10", "no writes after halt", 32'(we_cnt), 32'(we_exp));
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // directed: reset while halted brings the core back to running at address 0 (R1)
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "halt cleared by reset", 32'(halted), 32'h0);
    check("R1", "pc cleared by reset", 32'(pc_out), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule